// File: doc/BRIEF.md
# CAN Fault Confinement State Classifier

This block watches a snapshot of a CAN controller's error-flag byte, its status byte and its transmit and receive error counters. Each time a new snapshot is offered, it works out the node's fault-confinement state (error-active, error-warning, error-passive or bus-off) and compares it with the state it holds. When they differ, it raises a one-cycle change event. The event says whether the change is charged to the transmit side, the receive side or both, and it carries a copy of both counters taken at that moment.

When a bus-error interrupt is present and reporting is enabled, the block also reduces the protocol-error flags to a single one-hot cause. If the node falls to bus-off while automatic restart is disabled, the block asks for sleep mode and freezes until an explicit restart. The counters themselves are computed elsewhere.

Top module: `can_fc_classifier`

## Requirements
- R1: After reset, `fc_state` is 0 (error-active). `chg_evt`, `cause_vld`, `sleep_req` and `halted` are all 0.
- R2: When error-flag bit 7 is set, the computed state is bus-off (3), whatever the other bits are.
- R3: When bit 7 is clear and either bit 6 or bit 5 of the error flags is set, the state is error-passive (2).
- R4: When error bits 7..5 are clear, the state is error-warning (1) if status bit 4 is set, and error-active (0) if it is not.
- R5: Results appear in the cycle after a `sample` pulse. `chg_evt` is high for exactly that one cycle, and only when the computed state differs from the held state. A snapshot that gives the same state causes no event.
- R6: On an event, `chg_tx` = (tx_cnt >= rx_cnt) and `chg_rx` = (tx_cnt <= rx_cnt), so equal counts set both. `evt_tx_cnt` and `evt_rx_cnt` hold the counters of that snapshot.
- R7: `cause_vld` pulses only when `bus_err_irq`, `report_en` and a nonzero error-flag field [4:0] are all present. The flag bits are bit error = 4, form = 3, CRC = 2, ack = 1, stuff = 0. The one-hot `cause` gives bit error the highest priority, then form, stuff, CRC and ack. Its encoding is [4] bit, [3] form, [2] stuff, [1] CRC, [0] ack.
- R8: Entering bus-off with `auto_restart` low gives a one-cycle `sleep_req`, sets `halted` and reports no cause for that snapshot. While halted, snapshots change nothing. With `auto_restart` high, no halt occurs.
- R9: A `restart` pulse clears `halted` and returns the state to error-active without an event.
- R10: Inputs presented without `sample` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 1 | Snapshot strobe |
| err_flags | input | 8 | Error-flag byte |
| stat_flags | input | 8 | Status byte (bit 4 = warning) |
| tx_cnt | input | CNT_W | Transmit error counter |
| rx_cnt | input | CNT_W | Receive error counter |
| bus_err_irq | input | 1 | Bus-error interrupt flag |
| report_en | input | 1 | Enable protocol-error reporting |
| auto_restart | input | 1 | Automatic recovery from bus-off enabled |
| restart | input | 1 | Leave the halted state |
| fc_state | output | 2 | Held state: 0 active, 1 warning, 2 passive, 3 bus-off |
| chg_evt | output | 1 | State-change pulse |
| chg_tx | output | 1 | Change charged to transmit side |
| chg_rx | output | 1 | Change charged to receive side |
| evt_tx_cnt | output | CNT_W | Transmit counter latched at event |
| evt_rx_cnt | output | CNT_W | Receive counter latched at event |
| cause_vld | output | 1 | Protocol-error cause pulse |
| cause | output | 5 | One-hot protocol-error cause |
| sleep_req | output | 1 | Sleep-mode request pulse |
| halted | output | 1 | Frozen after bus-off |

## Verification
The bench builds the block with its default counter width of 8 bits. That width lets it drive counts of 255 alongside small values, so both sides of the counter comparison and the equal-count case are reached without wrap-around. Every state transition and every cause priority level is reachable at this width, and so are the halt and restart path and the no-sample case.

// File: rtl/can_fc_classifier.sv
module can_fc_classifier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [7:0]       err_flags,
  input  logic [7:0]       stat_flags,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             bus_err_irq,
  input  logic             report_en,
  input  logic             auto_restart,
  input  logic             restart,
  output logic [1:0]       fc_state,
  output logic             chg_evt,
  output logic             chg_tx,
  output logic             chg_rx,
  output logic [CNT_W-1:0] evt_tx_cnt,
  output logic [CNT_W-1:0] evt_rx_cnt,
  output logic             cause_vld,
  output logic [4:0]       cause,
  output logic             sleep_req,
  output logic             halted
);
  localparam logic [1:0] ST_ACT = 2'd0, ST_WARN = 2'd1, ST_PASS = 2'd2, ST_OFF = 2'd3;

  logic [1:0] nxt_state;
  logic       proc, differs, to_halt, prot_hit;
  logic [4:0] pick;

  assign proc     = sample && !halted && !restart;
  assign nxt_state = err_flags[7]        ? ST_OFF  :
                     (|err_flags[6:5])   ? ST_PASS :
                     stat_flags[4]       ? ST_WARN : ST_ACT;
  assign differs  = nxt_state != fc_state;
  assign to_halt  = differs && nxt_state == ST_OFF && !auto_restart;
  assign prot_hit = bus_err_irq && report_en && (|err_flags[4:0]);

  always_comb begin
    pick = 5'b0;
    if      (err_flags[4]) pick[4] = 1'b1;
    else if (err_flags[3]) pick[3] = 1'b1;
    else if (err_flags[0]) pick[2] = 1'b1;
    else if (err_flags[2]) pick[1] = 1'b1;
    else if (err_flags[1]) pick[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fc_state   <= ST_ACT;
      chg_evt    <= 1'b0;
      chg_tx     <= 1'b0;
      chg_rx     <= 1'b0;
      evt_tx_cnt <= '0;
      evt_rx_cnt <= '0;
      cause_vld  <= 1'b0;
      cause      <= 5'b0;
      sleep_req  <= 1'b0;
      halted     <= 1'b0;
    end else begin
      chg_evt   <= 1'b0;
      cause_vld <= 1'b0;
      sleep_req <= 1'b0;
      if (restart) begin
        halted   <= 1'b0;
        fc_state <= ST_ACT;
      end else if (proc) begin
        if (differs) begin
          fc_state   <= nxt_state;
          chg_evt    <= 1'b1;
          chg_tx     <= tx_cnt >= rx_cnt;
          chg_rx     <= tx_cnt <= rx_cnt;
          evt_tx_cnt <= tx_cnt;
          evt_rx_cnt <= rx_cnt;
        end
        if (to_halt) begin
          halted    <= 1'b1;
          sleep_req <= 1'b1;
        end else if (prot_hit) begin
          cause_vld <= 1'b1;
          cause     <= pick;
        end
      end
    end
  end

  p_evt_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> (chg_tx || chg_rx));
  p_evt_changed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> fc_state != $past(fc_state));
  p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cause_vld |-> $countones(cause) == 1);
  p_sleep_busoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (halted && fc_state == ST_OFF && !cause_vld));
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> ($stable(fc_state) && !chg_evt));
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!halted && fc_state == ST_ACT && !chg_evt));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !restart) |=> ($stable(fc_state) && !chg_evt && !cause_vld));
endmodule

// File: tb/sim_can_fc_classifier.sv
module sim_can_fc_classifier;
  localparam int CLK_NS = 10;
  localparam int W = 8;

  typedef struct packed {
    logic [7:0] err; logic [7:0] st; logic [7:0] tec; logic [7:0] rec;
    logic irq; logic en; logic [1:0] es; logic ev; logic et; logic er; logic [4:0] ec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 8'h10,  8'd10,  8'd5,  1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 5'b00000}, // R4 R6 warning, tx
    '{8'h00, 8'h10,  8'd10,  8'd5,  1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 5'b00000}, // R5 same state
    '{8'h40, 8'h10,  8'd130, 8'd20, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 5'b00000}, // R3 passive
    '{8'h20, 8'h10,  8'd3,   8'd140,1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 5'b00000}, // R3 rx passive, no event
    '{8'h00, 8'h00,  8'd7,   8'd7,  1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 5'b00000}, // R6 equal counts
    '{8'h1F, 8'h00,  8'd1,   8'd1,  1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b10000}, // R7 bit error
    '{8'h0F, 8'h00,  8'd1,   8'd1,  1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b01000}, // R7 form
    '{8'h07, 8'h00,  8'd1,   8'd1,  1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00100}, // R7 stuff over crc
    '{8'h06, 8'h00,  8'd1,   8'd1,  1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00010}, // R7 crc
    '{8'h02, 8'h00,  8'd1,   8'd1,  1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00001}, // R7 ack
    '{8'h02, 8'h00,  8'd1,   8'd1,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R7 disabled
    '{8'h02, 8'h00,  8'd1,   8'd1,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b00000}, // R7 no irq
    '{8'h80, 8'h10,  8'd255, 8'd100,1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 5'b00000}, // R2 bus-off, auto restart
    '{8'hE0, 8'h10,  8'd255, 8'd100,1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 5'b00000}, // R2 stays
    '{8'h00, 8'h00,  8'd0,   8'd9,  1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 5'b00000}, // R6 rx side
    '{8'h48, 8'h00,  8'd200, 8'd1,  1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 5'b01000}  // R7 cause with change
  };

  logic clk = 1'b0, rst_n = 1'b0, sample = 1'b0;
  logic [7:0] err_flags = '0, stat_flags = '0;
  logic [W-1:0] tx_cnt = '0, rx_cnt = '0;
  logic bus_err_irq = 1'b0, report_en = 1'b0, auto_restart = 1'b1, restart = 1'b0;
  logic [1:0] fc_state;
  logic chg_evt, chg_tx, chg_rx, cause_vld, sleep_req, halted;
  logic [W-1:0] evt_tx_cnt, evt_rx_cnt;
  logic [4:0] cause;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  can_fc_classifier #(.CNT_W(W)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic strobe);
    @(negedge clk);
    err_flags = v.err; stat_flags = v.st; tx_cnt = v.tec; rx_cnt = v.rec;
    bus_err_irq = v.irq; report_en = v.en; sample = strobe;
    @(negedge clk);
    sample = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", fc_state, 0);
    chk("R1 outputs", {chg_evt, cause_vld, sleep_req, halted}, 0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i], 1'b1);
      chk($sformatf("R2-4 state row%0d", i), fc_state, TBL[i].es);
      chk($sformatf("R5 event row%0d", i), chg_evt, TBL[i].ev);
      chk($sformatf("R7 cause_vld row%0d", i), cause_vld, |TBL[i].ec);
      if (TBL[i].ev) begin
        chk($sformatf("R6 sides row%0d", i), {chg_tx, chg_rx}, {TBL[i].et, TBL[i].er});
        chk($sformatf("R6 counts row%0d", i), {evt_tx_cnt, evt_rx_cnt}, {TBL[i].tec, TBL[i].rec});
      end
      if (|TBL[i].ec) chk($sformatf("R7 cause row%0d", i), cause, TBL[i].ec);
      @(negedge clk);
      chk($sformatf("R5 one cycle row%0d", i), chg_evt, 0);
    end

    // R10: no strobe, no effect (state is passive here)
    apply('{8'h80, 8'h00, 8'd9, 8'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b0}, 1'b0);
    chk("R10 state", fc_state, 2);
    chk("R10 pulses", {chg_evt, cause_vld, sleep_req}, 0);

    // R8: bus-off with auto restart off
    auto_restart = 1'b0;
    apply('{8'h90, 8'h00, 8'd250, 8'd3, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b0}, 1'b1);
    chk("R8 state", fc_state, 3);
    chk("R8 sleep/halt", {sleep_req, halted, chg_evt}, 3'b111);
    chk("R8 no cause", cause_vld, 0);
    @(negedge clk);
    chk("R8 sleep pulse", sleep_req, 0);
    apply('{8'h00, 8'h00, 8'd0, 8'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 5'b0}, 1'b1);
    chk("R8 frozen state", fc_state, 3);
    chk("R8 frozen outputs", {chg_evt, halted, cause_vld}, 3'b010);

    // R9: restart
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk("R9 state", fc_state, 0);
    chk("R9 cleared", {halted, chg_evt}, 0);
    apply('{8'h40, 8'h00, 8'd5, 8'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 5'b0}, 1'b1);
    chk("R9 resumes", {fc_state, chg_evt}, {2'd2, 1'b1});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule